// File: doc/BRIEF.md
# Rotate-Left-Through-Carry Execution Unit

This block executes one instruction of an 8-bit core: a rotate of a data-memory byte one place to the left through the carry flag. Each cycle it looks at a 16-bit instruction word. When the word carries the rotate opcode and is marked valid, the block works in a single clock edge. It forms a 12-bit data-memory address from the 8-bit file operand, reads the byte and rotates it. It then updates the carry, negative and zero flags and writes the result either to the working register or back to the same memory byte.

The address comes from one of two sources, chosen per instruction by an access bit. In access mode the operand is split: low operands reach the bottom of memory and high operands reach the top page. In banked mode a 4-bit bank select supplies the upper address bits. The block holds a 4096-byte register-file model, the working register and the status register. A plain load/read port on the register-file model lets the surrounding logic preload and inspect memory.

Top module: `rlc_exec_unit`

## Requirements
- R1: An instruction runs only when `instrValid` is high and `instrWord[15:10]` equals binary 001101. Otherwise W, STATUS and memory keep their values, apart from any load through the memory port, and `done` stays low.
- R2: The result equals the operand shifted left by one place, with the old carry (STATUS bit 0) placed in result bit 0.
- R3: After an instruction, STATUS bit 0 (carry) equals operand bit 7.
- R4: After an instruction, STATUS bit 4 (negative) equals result bit 7 and STATUS bit 2 (zero) is set exactly when the 8-bit result is zero. All other STATUS bits read 0.
- R5: With `instrWord[9]` (destination bit) at 0, the result goes to W and the memory byte is left unchanged.
- R6: With `instrWord[9]` at 1, the result is written back to the addressed memory byte and W is left unchanged.
- R7: With `instrWord[8]` (access bit) at 0, file operand f in 0x00–0x7F addresses 0x000–0x07F and f in 0x80–0xFF addresses 0xF80–0xFFF. `bankSel` has no effect.
- R8: With `instrWord[8]` at 1, the address is {bankSel, f}.
- R9: Results appear one clock edge after the instruction is presented, and `done` is high for exactly that following cycle. Instructions may run back to back, and each one reads what the previous one wrote.
- R10: While `rstN` is low, W, STATUS and `done` are 0.
- R11: When `memWe` is high, `memWdata` is stored at `memAddr` on the clock edge. `memRdata` always shows the byte at `memAddr`. A result written back on the same edge to the same address overrides the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 16 | Instruction word |
| bankSel | input | 4 | Bank number used for banked addressing |
| memWe | input | 1 | Load strobe for the register-file model |
| memAddr | input | 12 | Load/read address of the register-file model |
| memWdata | input | 8 | Load data |
| memRdata | output | 8 | Byte stored at memAddr |
| wReg | output | 8 | Working register |
| statusReg | output | 8 | Status register (bit 0 carry, bit 2 zero, bit 4 negative) |
| done | output | 1 | High for the cycle after an instruction ran |

## Verification
The rotate is tried with operands whose top bit is set and clear, under an incoming carry of 0 and of 1. This separates a true rotate through carry from a plain shift, and catches a carry taken from the wrong bit. Operands that rotate to zero, and others that rotate to a set top bit, show whether the zero and negative flags follow the result rather than the operand. Words that differ from the opcode in one bit, and matching words with valid low, show that decode is exact. Operands on both sides of 0x80 in access mode, run with several bank numbers, tell the access split apart from banked addressing. A long random run checks every cycle against a behavioural model, including back-to-back instructions on the same byte.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  localparam int DATA_W = 8;
  localparam logic [5:0] RLC_OPCODE = 6'b001101;
  localparam int STAT_C = 0;
  localparam int STAT_Z = 2;
  localparam int STAT_N = 4;

  typedef struct packed {
    logic exec;
    logic toFile;
    logic toW;
    logic banked;
  } rlcStrobe_t;
endpackage

// File: rtl/rlc_ctrl.sv
module rlc_ctrl
  import rlc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrValid,
  input  logic [7:0] opHigh,
  output rlcStrobe_t strobe,
  output logic       done
);
  logic opMatch;
  logic execNow;

  assign opMatch = (opHigh[7:2] == RLC_OPCODE);
  assign execNow = instrValid && opMatch;

  always_comb begin
    strobe.exec   = execNow;
    strobe.toFile = execNow && opHigh[1];
    strobe.toW    = execNow && !opHigh[1];
    strobe.banked = opHigh[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= execNow;
  end

  // R1: no done pulse after a cycle without a valid matching opcode
  assert_no_done_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(instrValid && opMatch) |=> !done);

  // R9: done follows every executed instruction
  assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.exec |=> done);

  // R5: only one destination per instruction
  assert_single_dest_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.toW, strobe.toFile}));
endmodule

// File: rtl/rlc_addr_gen.sv
module rlc_addr_gen #(
  parameter int FILE_W = 8,
  parameter int ADDR_W = 12,
  parameter int ACCESS_SPLIT = 128
) (
  input  logic [FILE_W-1:0]        fileOp,
  input  logic [ADDR_W-FILE_W-1:0] bankSel,
  input  logic                     banked,
  output logic [ADDR_W-1:0]        addr
);
  localparam int BANK_W = ADDR_W - FILE_W;
  localparam logic [BANK_W-1:0] LOW_PAGE  = '0;
  localparam logic [BANK_W-1:0] HIGH_PAGE = '1;

  logic [ADDR_W-1:0] accessAddr;

  always_comb begin
    if (int'(fileOp) < ACCESS_SPLIT) accessAddr = {LOW_PAGE, fileOp};
    else                             accessAddr = {HIGH_PAGE, fileOp};
  end

  assign addr = banked ? {bankSel, fileOp} : accessAddr;
endmodule

// File: rtl/rlc_datapath.sv
module rlc_datapath
  import rlc_pkg::*;
#(
  parameter int FILE_W = 8,
  parameter int ADDR_W = 12,
  parameter int ACCESS_SPLIT = 128
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rlcStrobe_t               strobe,
  input  logic [FILE_W-1:0]        fileOp,
  input  logic [ADDR_W-FILE_W-1:0] bankSel,
  input  logic                     memWe,
  input  logic [ADDR_W-1:0]        memAddr,
  input  logic [DATA_W-1:0]        memWdata,
  output logic [DATA_W-1:0]        memRdata,
  output logic [DATA_W-1:0]        wReg,
  output logic [DATA_W-1:0]        statusReg
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] execAddr;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] result;
  logic              carryIn;
  logic [DATA_W-1:0] nextStatus;

  rlc_addr_gen #(
    .FILE_W(FILE_W),
    .ADDR_W(ADDR_W),
    .ACCESS_SPLIT(ACCESS_SPLIT)
  ) i_addr (
    .fileOp (fileOp),
    .bankSel(bankSel),
    .banked (strobe.banked),
    .addr   (execAddr)
  );

  assign operand  = mem[execAddr];
  assign memRdata = mem[memAddr];
  assign carryIn  = statusReg[STAT_C];
  assign result   = {operand[DATA_W-2:0], carryIn};

  always_comb begin
    nextStatus         = '0;
    nextStatus[STAT_C] = operand[DATA_W-1];
    nextStatus[STAT_N] = result[DATA_W-1];
    nextStatus[STAT_Z] = (result == '0);
  end

  always_ff @(posedge clk) begin
    if (memWe)         mem[memAddr]  <= memWdata;
    if (strobe.toFile) mem[execAddr] <= result;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wReg      <= '0;
      statusReg <= '0;
    end else begin
      if (strobe.toW)  wReg      <= result;
      if (strobe.exec) statusReg <= nextStatus;
    end
  end

  // R3: carry picks up the operand's top bit
  assert_carry_msb_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.exec |=> statusReg[STAT_C] == $past(operand[DATA_W-1]));

  // R2: W receives the operand rotated with the previous carry
  assert_rotate_w_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.toW |=> wReg == {$past(operand[DATA_W-2:0]), $past(statusReg[STAT_C])});

  // R4: flags agree with the value that reached W
  assert_flags_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.toW |=> (statusReg[STAT_N] == wReg[DATA_W-1]) && (statusReg[STAT_Z] == (wReg == '0)));

  // R6: W holds unless the instruction targets W
  assert_w_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.toW |=> $stable(wReg));

  // R1: status holds when nothing runs
  assert_status_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.exec |=> $stable(statusReg));
endmodule

// File: rtl/rlc_exec_unit.sv
module rlc_exec_unit
  import rlc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int ACCESS_SPLIT = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [15:0]       instrWord,
  input  logic [3:0]        bankSel,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memWdata,
  output logic [7:0]        memRdata,
  output logic [7:0]        wReg,
  output logic [7:0]        statusReg,
  output logic              done
);
  rlcStrobe_t strobe;

  rlc_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instrValid(instrValid),
    .opHigh    (instrWord[15:8]),
    .strobe    (strobe),
    .done      (done)
  );

  rlc_datapath #(
    .FILE_W(8),
    .ADDR_W(ADDR_W),
    .ACCESS_SPLIT(ACCESS_SPLIT)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .fileOp   (instrWord[7:0]),
    .bankSel  (bankSel),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memRdata (memRdata),
    .wReg     (wReg),
    .statusReg(statusReg)
  );
endmodule

// File: tb/test_rlc_exec_unit.sv
module test_rlc_exec_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic [3:0]  bankSel = '0;
  logic        memWe = 1'b0;
  logic [11:0] memAddr = '0;
  logic [7:0]  memWdata = '0;
  logic [7:0]  memRdata;
  logic [7:0]  wReg;
  logic [7:0]  statusReg;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] refMem [4096];
  bit         known [4096];
  logic [7:0] refW = '0;
  logic [7:0] refStat = '0;
  logic       refDone = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rlc_exec_unit i_rlc_exec_unit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .bankSel(bankSel), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .wReg(wReg), .statusReg(statusReg), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, advance model, compare at the next negedge
  task automatic cycle(input logic v, input logic [15:0] word, input logic [3:0] bank,
                       input logic we, input logic [11:0] a, input logic [7:0] wd);
    logic exec;
    logic [11:0] xa;
    logic [7:0] op, res, ns;
    instrValid = v; instrWord = word; bankSel = bank;
    memWe = we; memAddr = a; memWdata = wd;
    exec = v && (word[15:10] == 6'b001101);
    xa = '0; res = '0; ns = '0;
    if (exec) begin
      if (word[8]) xa = {bank, word[7:0]};
      else         xa = (word[7:0] < 8'h80) ? {4'h0, word[7:0]} : {4'hF, word[7:0]};
      op  = refMem[xa];
      res = {op[6:0], refStat[0]};
      ns  = '0;
      ns[0] = op[7];
      ns[4] = res[7];
      ns[2] = (res == 8'h00);
    end
    if (we) begin refMem[a] = wd; known[a] = 1; end
    if (exec) begin
      refStat = ns;
      if (word[9]) begin refMem[xa] = res; known[xa] = 1; end
      else refW = res;
    end
    refDone = exec;
    @(negedge clk);
    check(wReg == refW, "R5", "W register", wReg, refW);
    check(statusReg == refStat, "R4", "STATUS", statusReg, refStat);
    check(done == refDone, "R9", "done strobe", done, refDone);
    if (known[a]) check(memRdata == refMem[a], "R6", "memory byte", memRdata, refMem[a]);
  endtask

  task automatic idle_read(input logic [11:0] a);
    cycle(1'b0, 16'h0000, 4'h0, 1'b0, a, 8'h00);
  endtask

  task automatic load(input logic [11:0] a, input logic [7:0] d);
    cycle(1'b0, 16'h0000, 4'h0, 1'b1, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) known[i] = 0;
    repeat (3) @(negedge clk);
    // R10: reset values
    check(wReg == 8'h00, "R10", "W in reset", wReg, 0);
    check(statusReg == 8'h00, "R10", "STATUS in reset", statusReg, 0);
    check(done == 1'b0, "R10", "done in reset", done, 0);
    rstN = 1'b1;

    // R11: preload every byte through the load port
    for (int i = 0; i < 4096; i++) load(i[11:0], 8'((i * 37 + 11) ^ (i >> 4)));

    // clear carry: rotate a zero byte into W
    load(12'h000, 8'h00);
    cycle(1'b1, 16'h3400, 4'h0, 1'b0, 12'h000, 8'h00);
    cycle(1'b1, 16'h3400, 4'h0, 1'b0, 12'h000, 8'h00);
    check(statusReg[0] == 1'b0, "R3", "carry cleared", statusReg[0], 0);

    // R2 R3 R5: 1110_0110 with carry 0 to W gives 1100_1100, carry 1
    load(12'h025, 8'hE6);
    cycle(1'b1, 16'h3425, 4'h0, 1'b0, 12'h025, 8'h00);
    check(wReg == 8'hCC, "R2", "rotated value in W", wReg, 8'hCC);
    check(statusReg == 8'h11, "R3", "carry and negative set", statusReg, 8'h11);
    check(memRdata == 8'hE6, "R5", "source byte untouched", memRdata, 8'hE6);

    // R4: 1000_0000 with carry 0 rotates to zero, carry 1
    load(12'h000, 8'h00);
    cycle(1'b1, 16'h3400, 4'h0, 1'b0, 12'h000, 8'h00); // carry now 0
    load(12'h010, 8'h80);
    cycle(1'b1, 16'h3410, 4'h0, 1'b0, 12'h010, 8'h00);
    check(wReg == 8'h00, "R4", "zero result", wReg, 0);
    check(statusReg == 8'h05, "R4", "zero and carry flags", statusReg, 8'h05);

    // R7 R6: access mode, high operand reaches top page, bank ignored
    load(12'hF90, 8'h01);
    load(12'h390, 8'h40);
    cycle(1'b1, 16'h3690, 4'h3, 1'b0, 12'hF90, 8'h00);
    check(memRdata == 8'h03, "R7", "top page byte rotated", memRdata, 8'h03);
    idle_read(12'h390);
    check(memRdata == 8'h40, "R7", "banked byte untouched", memRdata, 8'h40);
    check(wReg == 8'h00, "R6", "W unchanged on file write", wReg, 0);

    // R8: banked mode uses bank select
    cycle(1'b1, 16'h3790, 4'h3, 1'b0, 12'h390, 8'h00);
    check(memRdata == 8'h80, "R8", "banked byte rotated", memRdata, 8'h80);

    // R1: near-miss opcodes and invalid words
    cycle(1'b1, 16'h3C25, 4'h0, 1'b0, 12'h025, 8'h00);
    check(done == 1'b0, "R1", "no done on wrong opcode", done, 0);
    cycle(1'b1, 16'h1425, 4'h0, 1'b0, 12'h025, 8'h00);
    cycle(1'b0, 16'h3625, 4'h0, 1'b0, 12'h025, 8'h00);
    check(memRdata == 8'hE6, "R1", "memory held when invalid", memRdata, 8'hE6);

    // R9: back-to-back writes to one byte
    load(12'h0A0, 8'h81);
    cycle(1'b1, 16'h3620, 4'h0, 1'b0, 12'h0A0, 8'h00);
    cycle(1'b1, 16'h3620, 4'h0, 1'b0, 12'h0A0, 8'h00);
    cycle(1'b1, 16'h3620, 4'h0, 1'b0, 12'h0A0, 8'h00);

    // R11: load and write-back to the same address on one edge
    cycle(1'b1, 16'h3620, 4'h0, 1'b1, 12'h020, 8'h55);

    // random run compared each cycle against the model
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      logic [11:0] ra;
      w = 16'($urandom);
      if ($urandom_range(0, 9) < 7) w[15:10] = 6'b001101;
      else if ($urandom_range(0, 1) == 1) w[15:10] = 6'b001101 ^ (6'd1 << $urandom_range(0, 5));
      if ($urandom_range(0, 3) == 0) w[7:0] = 8'h7F + 8'($urandom_range(0, 2));
      ra = 12'($urandom);
      cycle($urandom_range(0, 9) < 8, w, 4'($urandom), $urandom_range(0, 4) == 0,
            ra, 8'($urandom));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule